// File: doc/BRIEF.md
# Six-Channel PWM Generator with Counted Burst

The block produces six pulse-width-modulated outputs from one system clock. A shared prescaler divides the clock into PWM ticks. Each channel counts ticks up to its own 16-bit period value. Its output is in the active phase for as many ticks of each period as its compare value gives. A per-channel invert bit flips the output polarity, and it also flips the level the output holds while the channel is stopped.

Channel 0 can also run in a counted mode. It emits a programmed number of whole periods, then stops by itself, clears its own enable and raises a count-done flag. Every channel raises a period-end event at each period boundary. The events are gathered in a write-one-to-clear status register and gated by a mask register into one interrupt line.

All settings sit in a flat register file. Each word is reached through a synchronous write strobe with address and data, and read back combinationally on `reg_rdata`. Unused bits read as zero.

Each channel runs a small state machine with three states:
- `CH_IDLE`: the channel is stopped and drives its inactive level.
- `CH_RUN`: continuous output.
- `CH_BURST`: counted output, reachable only on channel 0.

Its transitions are:
- *start-run*: `CH_IDLE` to `CH_RUN` when the channel is enabled and counted mode is off or not present.
- *start-burst*: `CH_IDLE` to `CH_BURST` when channel 0 is enabled with counted mode selected.
- *stop*: `CH_RUN` or `CH_BURST` back to `CH_IDLE` when the enable is cleared.
- *burst-complete*: `CH_BURST` back to `CH_IDLE` when the last counted period ends.

Top module: `pwm_bank`

Register addresses (6-bit):

| Address | Contents |
|---|---|
| 0x00 | Prescaler, 8 bits |
| 0x01 | Channel 0 enable, bit 0 |
| 0x02 | Enables of channels 1 to 5, bit n |
| 0x03 | Counted-mode select for channel 0, bit 0 |
| 0x04 | Invert bits, bit n |
| 0x05 | Pulse count, 14 bits |
| 0x06 | Interrupt mask |
| 0x07 | Interrupt status |
| 0x10+2n | Period of channel n |
| 0x11+2n | Compare value of channel n |

## Requirements
- R1: The prescaler (address 0x00, 8 bits) makes one PWM tick every prescaler+1 clocks, so an output period lasts period×(prescaler+1) clocks.
- R2: Each period has exactly compare ticks in the active phase. A compare of 0 never enters the active phase. A compare at or above the period keeps the output active the whole time.
- R3: Channel 0 is enabled by bit 0 at 0x01, and channel n (1 to 5) by bit n at 0x02. Bit 0 at 0x02 reads 0 and starts nothing. A stopped channel drives its inactive level, and a started channel begins a period in the active phase.
- R4: Bit n of the invert register (0x04) flips output n, both while running and while stopped. The output is active high when the bit is 0 and low when it is 1.
- R5: A period or compare write made while a channel runs takes effect only at the next period boundary, so the current period keeps its old length and active time.
- R6: With bit 0 of 0x03 set when channel 0 starts, the channel emits exactly the number of periods held at 0x05. It then clears its enable bit, returns to its inactive level and sets the count-done flag. Count-done takes priority over a software write to the enable in the same cycle.
- R7: The pulse count field is 14 bits wide (a write of 0xFFFF reads back 0x3FFF). A count of 0 behaves as a count of 1.
- R8: Status (0x07) holds count-done at bit 0 and the period-end event of channel n at bit n+2. Bit 1 always reads 0. Writing 1 to a bit clears it, and a new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status bit is set whose mask bit (0x06, same layout) is also set.
- R10: After reset every register reads 0, all outputs are low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pwm_out | output | 6 | PWM outputs, bit n is channel n |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a period or compare write that lands inside a running period. It must be held back until the boundary, and the only evidence is the length of that one period. The bench watches the output for a rising edge, issues the two writes a fixed number of cycles later, and measures the interrupted period and then the next one. Counted bursts are driven with random and edge counts (zero and small values), and each ends with the self-cleared enable, the done flag and the interrupt observed through reads. Random channel, prescaler, period, compare and polarity settings cover the continuous case.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_PRESC   = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN0     = 6'h01;
    localparam logic [ADDR_W-1:0] A_ENX     = 6'h02;
    localparam logic [ADDR_W-1:0] A_MODE    = 6'h03;
    localparam logic [ADDR_W-1:0] A_INV     = 6'h04;
    localparam logic [ADDR_W-1:0] A_COUNT   = 6'h05;
    localparam logic [ADDR_W-1:0] A_MASK    = 6'h06;
    localparam logic [ADDR_W-1:0] A_STAT    = 6'h07;
    localparam logic [ADDR_W-1:0] A_CH_BASE = 6'h10;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_BURST = 2'd2
    } ch_state_e;

    function automatic logic [ADDR_W-1:0] ch_max_addr(input int n);
        return A_CH_BASE + ADDR_W'(2 * n);
    endfunction

    function automatic logic [ADDR_W-1:0] ch_cmp_addr(input int n);
        return A_CH_BASE + ADDR_W'(2 * n + 1);
    endfunction

endpackage

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] presc,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;

    // ">=" rather than "==": lowering the divider mid-count never
    // forces a full wrap of the counter.
    always_comb tick = (div_q >= presc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int CNT_W   = 16,
    parameter int PULSE_W = 14,
    parameter int DIV_W   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           burst_done,
    input  logic [NUM_CH-1:0]              period_evt,
    output logic [DIV_W-1:0]               presc_q,
    output logic [NUM_CH-1:0]              en_q,
    output logic                           mode_q,
    output logic [NUM_CH-1:0]              inv_q,
    output logic [PULSE_W-1:0]             goal_q,
    output logic [NUM_CH+1:0]              mask_q,
    output logic [NUM_CH+1:0]              status_q,
    output logic [NUM_CH-1:0][CNT_W-1:0]   max_q,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_q,
    output logic [DATA_W-1:0]              rdata
);

    localparam int ST_W = NUM_CH + 2;

    logic [ST_W-1:0] st_set;
    logic [ST_W-1:0] st_clr;

    always_comb begin
        st_set = {period_evt, 1'b0, burst_done};
        st_clr = (we && addr == A_STAT) ? wdata[ST_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= '0;
            en_q     <= '0;
            mode_q   <= 1'b0;
            inv_q    <= '0;
            goal_q   <= '0;
            mask_q   <= '0;
            status_q <= '0;
            max_q    <= '0;
            cmp_q    <= '0;
        end else begin
            if (we) begin
                if (addr == A_PRESC) presc_q <= wdata[DIV_W-1:0];
                if (addr == A_EN0)   en_q[0] <= wdata[0];
                if (addr == A_ENX)   en_q[NUM_CH-1:1] <= wdata[NUM_CH-1:1];
                if (addr == A_MODE)  mode_q <= wdata[0];
                if (addr == A_INV)   inv_q <= wdata[NUM_CH-1:0];
                if (addr == A_COUNT) goal_q <= wdata[PULSE_W-1:0];
                if (addr == A_MASK)  mask_q <= wdata[ST_W-1:0];
                for (int n = 0; n < NUM_CH; n++) begin
                    if (addr == ch_max_addr(n)) max_q[n] <= wdata[CNT_W-1:0];
                    if (addr == ch_cmp_addr(n)) cmp_q[n] <= wdata[CNT_W-1:0];
                end
            end
            // completion of a counted burst beats a concurrent enable write
            if (burst_done) en_q[0] <= 1'b0;
            status_q <= (status_q & ~st_clr) | st_set;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_PRESC) rdata[DIV_W-1:0]    = presc_q;
        if (addr == A_EN0)   rdata[0]            = en_q[0];
        if (addr == A_ENX)   rdata[NUM_CH-1:1]   = en_q[NUM_CH-1:1];
        if (addr == A_MODE)  rdata[0]            = mode_q;
        if (addr == A_INV)   rdata[NUM_CH-1:0]   = inv_q;
        if (addr == A_COUNT) rdata[PULSE_W-1:0]  = goal_q;
        if (addr == A_MASK)  rdata[ST_W-1:0]     = mask_q;
        if (addr == A_STAT)  rdata[ST_W-1:0]     = status_q;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ch_max_addr(n)) rdata[CNT_W-1:0] = max_q[n];
            if (addr == ch_cmp_addr(n)) rdata[CNT_W-1:0] = cmp_q[n];
        end
    end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PULSE_W   = 14,
    parameter bit HAS_BURST = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en,
    input  logic               burst_req,
    input  logic               inv,
    input  logic [CNT_W-1:0]   max_in,
    input  logic [CNT_W-1:0]   cmp_in,
    input  logic [PULSE_W-1:0] pulse_goal,
    output logic               pwm,
    output logic               period_evt,
    output logic               done,
    output logic               running
);

    ch_state_e state_q, state_d;

    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cur_max_q;
    logic [CNT_W-1:0]   cur_cmp_q;
    logic [PULSE_W-1:0] pulses_q;
    logic               wrap;
    logic               last_pulse;
    logic               step;

    always_comb begin
        wrap       = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cur_max_q};
        last_pulse = ({1'b0, pulses_q} + 1'b1) >= {1'b0, pulse_goal};
        step       = (state_q != CH_IDLE) && en && tick;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en) state_d = (HAS_BURST && burst_req) ? CH_BURST : CH_RUN;
            end
            CH_RUN: begin
                if (!en) state_d = CH_IDLE;
            end
            CH_BURST: begin
                if (!en)                            state_d = CH_IDLE;
                else if (tick && wrap && last_pulse) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // period counter and shadow copies of period/compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cur_max_q <= '0;
            cur_cmp_q <= '0;
            pulses_q  <= '0;
        end else if (state_q == CH_IDLE) begin
            if (en) begin
                cnt_q     <= '0;
                cur_max_q <= max_in;
                cur_cmp_q <= cmp_in;
                pulses_q  <= '0;
            end
        end else if (step) begin
            if (wrap) begin
                cnt_q     <= '0;
                cur_max_q <= max_in;
                cur_cmp_q <= cmp_in;
                if (state_q == CH_BURST) pulses_q <= pulses_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        running    = (state_q != CH_IDLE);
        pwm        = (running && (cnt_q < cur_cmp_q)) ^ inv;
        period_evt = step && wrap;
        done       = (state_q == CH_BURST) && step && wrap && last_pulse;
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int CNT_W   = 16,
    parameter int PULSE_W = 14,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              irq
);

    localparam int ST_W = NUM_CH + 2;

    logic [DIV_W-1:0]             presc_q;
    logic [NUM_CH-1:0]            en_vec;
    logic                         burst_mode;
    logic [NUM_CH-1:0]            inv_vec;
    logic [PULSE_W-1:0]           pulse_goal;
    logic [ST_W-1:0]              irq_mask;
    logic [ST_W-1:0]              status_q;
    logic [NUM_CH-1:0][CNT_W-1:0] max_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_vec;
    logic [NUM_CH-1:0]            evt_vec;
    logic [NUM_CH-1:0]            done_vec;
    logic [NUM_CH-1:0]            run_vec;
    logic                         burst_done;
    logic                         tick;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .PULSE_W(PULSE_W),
        .DIV_W  (DIV_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .burst_done(burst_done),
        .period_evt(evt_vec),
        .presc_q   (presc_q),
        .en_q      (en_vec),
        .mode_q    (burst_mode),
        .inv_q     (inv_vec),
        .goal_q    (pulse_goal),
        .mask_q    (irq_mask),
        .status_q  (status_q),
        .max_q     (max_vec),
        .cmp_q     (cmp_vec),
        .rdata     (reg_rdata)
    );

    pwm_bank_presc #(
        .DIV_W(DIV_W)
    ) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .presc(presc_q),
        .tick (tick)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_bank_chan #(
            .CNT_W    (CNT_W),
            .PULSE_W  (PULSE_W),
            .HAS_BURST(n == 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .en        (en_vec[n]),
            .burst_req ((n == 0) ? burst_mode : 1'b0),
            .inv       (inv_vec[n]),
            .max_in    (max_vec[n]),
            .cmp_in    (cmp_vec[n]),
            .pulse_goal((n == 0) ? pulse_goal : {PULSE_W{1'b0}}),
            .pwm       (pwm_out[n]),
            .period_evt(evt_vec[n]),
            .done      (done_vec[n]),
            .running   (run_vec[n])
        );
    end

    // only channel 0 can reach the burst state, so the OR is its done
    always_comb begin
        burst_done = |done_vec;
        irq        = |(status_q & irq_mask);
    end

endmodule

// File: rtl/pwm_bank_sva.sv
module pwm_bank_sva
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata_b0,
    input logic              tick,
    input logic [DIV_W-1:0]  presc,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] inv_vec,
    input logic [NUM_CH-1:0] run_vec,
    input logic              burst_done,
    input logic              done_flag,
    input logic [NUM_CH-1:0] pwm_out
);

    // R1: a divider above zero never gives ticks on two adjacent clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc != '0 && !(reg_we && reg_addr == A_PRESC)) |=> !tick);

    // R6: finishing a burst drops the channel 0 enable
    p_done_clears_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !en_vec[0]);

    // R8: finishing a burst raises the count-done flag
    p_done_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> done_flag);

    // R8: write-one clears the flag when no new completion coincides
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_STAT && wdata_b0 && !burst_done) |=> !done_flag);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // R3/R4: a stopped channel sits at its inactive level
        p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[k] |-> (pwm_out[k] == inv_vec[k]));

        // R3: a cleared enable stops the channel on the next clock
        p_stop_on_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[k] && !en_vec[k]) |=> !run_vec[k]);
    end

endmodule

bind pwm_bank pwm_bank_sva #(
    .NUM_CH(NUM_CH),
    .DIV_W (DIV_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .wdata_b0  (reg_wdata[0]),
    .tick      (tick),
    .presc     (presc_q),
    .en_vec    (en_vec),
    .inv_vec   (inv_vec),
    .run_vec   (run_vec),
    .burst_done(burst_done),
    .done_flag (status_q[0]),
    .pwm_out   (pwm_out)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
    import pwm_bank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [5:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic [NCH-1:0]  pwm_out;
    logic            irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pwm_out  (pwm_out),
        .irq      (irq)
    );

    function automatic int exp_active(input int cmp, input int p);
        return cmp * (p + 1);
    endfunction

    function automatic int exp_period(input int mx, input int p);
        return mx * (p + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic set_en(input int ch, input bit on);
        if (ch == 0) wr(A_EN0, 16'(on));
        else         wr(A_ENX, 16'(int'(on) << ch));
    endtask

    task automatic stop_all();
        wr(A_EN0, 16'h0);
        wr(A_ENX, 16'h0);
        wr(A_MODE, 16'h0);
    endtask

    // find a rising edge of the active level, then time one whole period
    task automatic measure(input int ch, input bit pol, output int hi, output int per);
        int guard;
        bit s, prev;
        guard = 0;
        prev = pwm_out[ch] ^ pol;
        while (guard < 4000) begin
            @(negedge clk); guard++;
            s = pwm_out[ch] ^ pol;
            if (s && !prev) break;
            prev = s;
        end
        hi = 1; per = 1; prev = 1'b1;
        while (guard < 4000) begin
            @(negedge clk); guard++;
            s = pwm_out[ch] ^ pol;
            if (s && !prev) break;
            per++;
            if (s) hi++;
            prev = s;
        end
    endtask

    task automatic run_burst(input int goal, input int want, input string tag);
        int rises, v;
        bit s, prev;
        wr(A_EN0, 16'h0);
        wr(A_STAT, 16'hFF);
        wr(A_MASK, 16'h01);
        wr(A_MODE, 16'h1);
        wr(A_COUNT, 16'(goal));
        wr(A_EN0, 16'h1);
        rises = 0;
        prev = pwm_out[0];
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            s = pwm_out[0];
            if (s && !prev) rises++;
            prev = s;
        end
        chk(tag, rises, want);
        rd(A_EN0, v);   chk("R6 enable self-cleared", v, 0);
        rd(A_STAT, v);  chk("R8 count-done at bit0", v & 1, 1);
        chk("R9 irq on masked done", int'(irq), 1);
        chk("R6 idle level after burst", int'(pwm_out[0]), 0);
        wr(A_STAT, 16'hFF);
        rd(A_STAT, v);  chk("R8 write-one clear", v, 0);
        chk("R9 irq drops after clear", int'(irq), 0);
        wr(A_MODE, 16'h0);
    endtask

    initial begin
        int v, hi, per, cnt;
        int ch, p, mx, cp, ivb;
        int tot, hcnt;
        bit s, prev;

        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 outputs low", int'(pwm_out), 0);
        chk("R10 irq low", int'(irq), 0);
        for (int a = 0; a < 8; a++) begin
            rd(6'(a), v);
            chk("R10 register zero", v, 0);
        end
        rd(ch_max_addr(5), v); chk("R10 period zero", v, 0);

        // R1/R2/R4: random continuous settings
        for (int it = 0; it < 8; it++) begin
            ch  = $urandom_range(0, 5);
            p   = $urandom_range(0, 3);
            mx  = $urandom_range(2, 20);
            cp  = $urandom_range(1, mx - 1);
            ivb = $urandom_range(0, 1);
            stop_all();
            wr(A_PRESC, 16'(p));
            wr(ch_max_addr(ch), 16'(mx));
            wr(ch_cmp_addr(ch), 16'(cp));
            wr(A_INV, 16'(ivb << ch));
            set_en(ch, 1'b1);
            repeat (3) @(negedge clk);
            measure(ch, ivb[0], hi, per);
            chk("R2 active ticks", hi, exp_active(cp, p));
            chk("R1 period clocks", per, exp_period(mx, p));
            set_en(ch, 1'b0);
            repeat (2) @(negedge clk);
            chk("R4 idle level follows invert", int'(pwm_out[ch]), ivb);
        end
        rd(A_PRESC, v); chk("R1 prescaler readback", v, p);

        // R2: compare above period, then compare zero
        stop_all();
        wr(A_INV, 16'h0);
        wr(A_PRESC, 16'h0);
        wr(ch_max_addr(2), 16'd5);
        wr(ch_cmp_addr(2), 16'd7);
        set_en(2, 1'b1);
        repeat (2) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(pwm_out[2]); end
        chk("R2 compare above period always active", cnt, 30);
        wr(ch_cmp_addr(2), 16'd0);
        repeat (10) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); cnt += int'(pwm_out[2]); end
        chk("R2 compare zero never active", cnt, 0);
        set_en(2, 1'b0);

        // R3: bit 0 of the shared enable is not channel 0
        wr(A_ENX, 16'h0001);
        repeat (3) @(negedge clk);
        rd(A_ENX, v); chk("R3 shared enable bit0 reads 0", v, 0);
        chk("R3 channel 0 not started", int'(pwm_out), 0);

        // R5: writes mid-period wait for the boundary
        wr(ch_max_addr(1), 16'd40);
        wr(ch_cmp_addr(1), 16'd10);
        set_en(1, 1'b1);
        repeat (3) @(negedge clk);
        prev = pwm_out[1];
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            s = pwm_out[1];
            if (s && !prev) break;
            prev = s;
        end
        tot = 1; hcnt = 1; prev = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (tot == 5) begin
                reg_we = 1'b1; reg_addr = ch_max_addr(1); reg_wdata = 16'd12;
            end else if (tot == 6) begin
                reg_we = 1'b1; reg_addr = ch_cmp_addr(1); reg_wdata = 16'd4;
            end else begin
                reg_we = 1'b0;
            end
            @(negedge clk);
            s = pwm_out[1];
            if (s && !prev) break;
            tot++;
            if (s) hcnt++;
            prev = s;
        end
        reg_we = 1'b0;
        chk("R5 interrupted period keeps old length", tot, 40);
        chk("R5 interrupted period keeps old compare", hcnt, 10);
        measure(1, 1'b0, hi, per);
        chk("R5 next period uses new length", per, 12);
        chk("R5 next period uses new compare", hi, 4);
        set_en(1, 1'b0);

        // R6/R7/R8/R9: counted bursts on channel 0
        stop_all();
        wr(ch_max_addr(0), 16'd6);
        wr(ch_cmp_addr(0), 16'd2);
        run_burst(5, 5, "R6 burst of five");
        for (int it = 0; it < 2; it++) begin
            cp = $urandom_range(1, 9);
            run_burst(cp, cp, "R6 random burst length");
        end
        run_burst(0, 1, "R7 zero count gives one pulse");
        run_burst(1, 1, "R6 single pulse burst");
        wr(A_COUNT, 16'hFFFF);
        rd(A_COUNT, v); chk("R7 count field 14 bits", v, 16'h3FFF);

        // R8/R9: period-end event of channel 3 at bit 5
        stop_all();
        wr(A_STAT, 16'hFF);
        wr(A_MASK, 16'h20);
        wr(ch_max_addr(3), 16'd50);
        wr(ch_cmp_addr(3), 16'd10);
        set_en(3, 1'b1);
        repeat (60) @(negedge clk);
        rd(A_STAT, v);
        chk("R8 channel 3 event at bit5", v & 16'h20, 16'h20);
        chk("R8 bit1 reads 0", v & 16'h2, 0);
        chk("R9 irq on masked event", int'(irq), 1);
        wr(A_STAT, 16'h20);
        rd(A_STAT, v);
        chk("R8 bit5 cleared", v & 16'h20, 0);
        chk("R9 irq low after clear", int'(irq), 0);
        wr(A_MASK, 16'h0);
        repeat (60) @(negedge clk);
        rd(A_STAT, v);
        chk("R8 event set again", v & 16'h20, 16'h20);
        chk("R9 masked-off event gives no irq", int'(irq), 0);
        set_en(3, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule